// File: doc/BRIEF.md
# Five-Level Noise-Shaping Modulator

This block is the digital loop at the back end of an oversampling audio DAC. An interpolation stage supplies signed 21-bit samples at eight times the audio sample rate. The modulator runs one loop update per `step` tick, and those ticks come at 64 times the audio rate. Each input sample therefore feeds eight consecutive loop updates. Every update emits a code from 0 to 4, which selects one level of a multi-level analog output stage.

The loop is a chain of three delaying integrators. The quantized output, converted back to a feedback value, is subtracted at the input of every integrator. Each accumulator clamps at its signed limits instead of wrapping, and a flag reports any update in which a stage clamped. The quantizer decides on the last integrator's current contents. Its decision points sit halfway between neighbouring feedback levels.

Top module: `dsm5_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `code` = 2, `code_vld` = 0 and `ovf` = 0, and all three accumulators and the input phase are cleared.
- R2: `code_vld` is high for exactly the cycle after each clock edge that saw `step` high. `code` and `ovf` change only at edges that saw `step` high.
- R3: `code` always lies in the range 0 to 4.
- R4: The input is loaded at the first step after reset and at every eighth step after that. At those steps `din` is used directly. At the seven steps in between, the held value is used and `din` has no effect.
- R5: Let S = 2^19, so that S times 2 equals the input full scale. A code c feeds back the value (c−2)·S. The quantizer output is the number of thresholds −1.5S, −0.5S, +0.5S and +1.5S that the last accumulator's value reaches or exceeds.
- R6: Each accumulator is 26 bits wide and saturates at −2^25 and 2^25−1. `ovf` is set after any step in which a stage saturated, and cleared after a step in which none did.
- R7: With `din` held at zero from reset, every emitted code is 2.
- R8: On each step the code is formed from the old third accumulator. The accumulators then update as: a1 += x − fb, a2 += old a1 − fb, a3 += old a2 − fb, where fb is the feedback value of that code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | One loop update at this edge (64× rate tick) |
| din | input | 21 | Signed input sample (8× rate) |
| code | output | 3 | Quantizer level, 0 to 4 |
| code_vld | output | 1 | Pulse: a new code was issued on the previous step |
| ovf | output | 1 | At least one stage saturated on the latest step |

## Verification
Any wrong accumulator value, sign or saturation point reaches the quantizer within at most three steps, because the chain has a depth of three. The error then shows as a different code, or as a wrong `ovf`. A wrong input phase or hold register changes the input term on the very next step. The bench therefore compares `code`, `code_vld` and `ovf` with a behavioural model on every clock. It uses gapped steps, junk values on the non-load steps, full-scale inputs of both signs, and a reset applied mid-run.

// File: rtl/dsm5_pkg.sv
package dsm5_pkg;
  typedef logic [2:0] code_t;
  localparam int    NLEV     = 5;
  localparam code_t CODE_MID = 3'd2;
endpackage

// File: rtl/dsm5_hold.sv
// Input hold with upsampling phase: loads on phase 0, holds otherwise.
module dsm5_hold #(
  parameter int DW  = 21,
  parameter int UPS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] cur
);
  localparam int PW = (UPS > 1) ? $clog2(UPS) : 1;

  logic [PW-1:0]        phase_q;
  logic signed [DW-1:0] hold_q;
  logic                 load;

  assign load = (phase_q == '0);
  assign cur  = load ? din : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      hold_q  <= '0;
    end else if (step) begin
      if (load) hold_q <= din;
      if (phase_q == PW'(UPS-1)) phase_q <= '0;
      else                       phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsm5_integ.sv
// One delaying integrator stage: acc += add_a - sub_b, saturating.
module dsm5_integ #(
  parameter int AW = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic signed [AW-1:0] add_a,
  input  logic signed [AW-1:0] sub_b,
  output logic signed [AW-1:0] acc,
  output logic                 clip
);
  localparam int SW = AW + 2;
  localparam logic signed [SW-1:0] HI = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [SW-1:0] LO = {3'b111, {(AW-1){1'b0}}};

  logic signed [SW-1:0] sum_w;
  logic signed [AW-1:0] nxt;

  assign sum_w = SW'(acc) + SW'(add_a) - SW'(sub_b);

  always_comb begin
    clip = 1'b0;
    nxt  = sum_w[AW-1:0];
    if (sum_w > HI) begin
      clip = 1'b1;
      nxt  = HI[AW-1:0];
    end else if (sum_w < LO) begin
      clip = 1'b1;
      nxt  = LO[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (step) acc <= nxt;
  end
endmodule

// File: rtl/dsm5_quant.sv
// Multi-level quantizer with mid-point thresholds and feedback mapping.
module dsm5_quant
  import dsm5_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 21
) (
  input  logic signed [AW-1:0] v,
  output code_t                code,
  output logic signed [AW-1:0] fb
);
  localparam int STEP = 1 << (DW - 2);
  localparam int MID  = (NLEV - 1) / 2;

  always_comb begin
    code = '0;
    for (int k = 0; k < NLEV - 1; k++) begin
      if (v >= AW'((2 * k - (NLEV - 2)) * STEP / 2)) code = code + 3'd1;
    end
    fb = AW'((int'(code) - MID) * STEP);
  end
endmodule

// File: rtl/dsm5_mod.sv
module dsm5_mod
  import dsm5_pkg::*;
#(
  parameter int DW    = 21,
  parameter int AW    = 26,
  parameter int UPS   = 8,
  parameter int ORDER = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic signed [DW-1:0] din,
  output logic [2:0]           code,
  output logic                 code_vld,
  output logic                 ovf
);
  logic signed [DW-1:0] cur;
  logic signed [AW-1:0] acc   [ORDER];
  logic signed [AW-1:0] st_in [ORDER];
  logic [ORDER-1:0]     clip;
  logic signed [AW-1:0] fb;
  code_t                qcode;

  dsm5_hold #(.DW(DW), .UPS(UPS)) u_hold (
    .clk(clk), .rst(rst), .step(step), .din(din), .cur(cur)
  );

  dsm5_quant #(.AW(AW), .DW(DW)) u_quant (
    .v(acc[ORDER-1]), .code(qcode), .fb(fb)
  );

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign st_in[g] = AW'(cur);
    end else begin : g_next
      assign st_in[g] = acc[g-1];
    end
    dsm5_integ #(.AW(AW)) u_integ (
      .clk(clk), .rst(rst), .step(step),
      .add_a(st_in[g]), .sub_b(fb), .acc(acc[g]), .clip(clip[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= CODE_MID;
      code_vld <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      code_vld <= step;
      if (step) begin
        code <= qcode;
        ovf  <= |clip;
      end
    end
  end
endmodule

// File: rtl/dsm5_mod_chk.sv
module dsm5_mod_chk (
  input logic       clk,
  input logic       rst,
  input logic       step,
  input logic [2:0] code,
  input logic       code_vld,
  input logic       ovf
);
  assert_rst_state_R1: assert property (@(posedge clk)
    rst |=> (code == 3'd2 && !code_vld && !ovf));

  assert_vld_after_step_R2: assert property (@(posedge clk) disable iff (rst)
    step |=> code_vld);

  assert_vld_cause_R2: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> $past(step));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(code) && $stable(ovf)));

  assert_code_range_R3: assert property (@(posedge clk) disable iff (rst)
    code <= 3'd4);

  assert_ovf_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(step));
endmodule

bind dsm5_mod dsm5_mod_chk u_chk (
  .clk(clk), .rst(rst), .step(step), .code(code), .code_vld(code_vld), .ovf(ovf)
);

// File: tb/dsm5_mod_bench.sv
module dsm5_mod_bench;
  localparam int     DW   = 21;
  localparam int     AW   = 26;
  localparam int     UPS  = 8;
  localparam longint S    = longint'(1) << (DW - 2);
  localparam longint AHI  = (longint'(1) << (AW - 1)) - 1;
  localparam longint ALO  = -(longint'(1) << (AW - 1));

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 step = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic [2:0]           code;
  logic                 code_vld;
  logic                 ovf;

  dsm5_mod u_dsm5_mod (
    .clk(clk), .rst(rst), .step(step), .din(din),
    .code(code), .code_vld(code_vld), .ovf(ovf)
  );

  always #4 clk = ~clk;  // 8-unit period: 125 MHz at 1 ns

  int n_chk = 0;
  int n_bad = 0;
  longint a1, a2, a3, hold_m;
  int  ph, m_code;
  bit  m_vld, m_ovf, dut_ovf_seen, done;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int quant(input longint v);
    int c = 0;
    if (v >= -3 * S / 2) c++;
    if (v >= -S / 2)     c++;
    if (v >=  S / 2)     c++;
    if (v >=  3 * S / 2) c++;
    return c;
  endfunction

  function automatic longint clampv(input longint v);
    if (v > AHI) return AHI;
    if (v < ALO) return ALO;
    return v;
  endfunction

  task automatic model_tick();
    longint x, fb, n1, n2, n3;
    int q;
    if (rst) begin
      a1 = 0; a2 = 0; a3 = 0; hold_m = 0; ph = 0;
      m_code = 2; m_vld = 0; m_ovf = 0;
    end else if (step) begin
      x = (ph == 0) ? longint'(din) : hold_m;  // R4
      if (ph == 0) hold_m = x;
      ph = (ph + 1) % UPS;
      q  = quant(a3);                          // R5
      fb = longint'(q - 2) * S;
      n1 = a1 + x - fb;                        // R8
      n2 = a2 + a1 - fb;
      n3 = a3 + a2 - fb;
      m_ovf = (n1 != clampv(n1)) || (n2 != clampv(n2)) || (n3 != clampv(n3));
      a1 = clampv(n1); a2 = clampv(n2); a3 = clampv(n3);
      m_code = q; m_vld = 1;
    end else begin
      m_vld = 0;
    end
  endtask

  task automatic cyc(input bit s, input longint d);
    step = s;
    din  = d[DW-1:0];
    @(posedge clk);
    model_tick();
    @(negedge clk);
    chk("R8 code", code, m_code);
    chk("R2 code_vld", code_vld, m_vld);
    chk("R6 ovf", ovf, m_ovf);
    chk("R3 range", (code <= 3'd4), 1);
    if (ovf) dut_ovf_seen = 1;
  endtask

  initial begin
    #1200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1, 12345);
    chk("R1 code", code, 2);
    chk("R1 vld", code_vld, 0);
    chk("R1 ovf", ovf, 0);
    rst = 1'b0;

    // R7: zero input keeps mid code
    for (int i = 0; i < 48; i++) begin
      cyc(1, 0);
      chk("R7 zero", code, 2);
    end

    // R4/R2: gapped steps, junk on non-load steps and idle cycles
    for (int i = 0; i < 96; i++) begin
      cyc(1, (ph == 0) ? 3000 : longint'($urandom));
      cyc(0, longint'($urandom));
      chk("R2 idle", code_vld, 0);
      cyc(0, longint'($urandom));
    end

    // R5/R8: triangle sweep, din changing every cycle
    for (int i = 0; i < 600; i++) begin
      cyc(1, longint'((i % 200) - 100) * 3000);
    end

    // R6: full scale of both signs
    for (int i = 0; i < 300; i++) cyc(1, (longint'(1) << (DW - 1)) - 1);
    for (int i = 0; i < 300; i++) cyc(1, -(longint'(1) << (DW - 1)));
    chk("R6 saturation seen", dut_ovf_seen, 1);

    // R1: reset mid-run, then zero input again (R7)
    rst = 1'b1;
    cyc(1, 77777);
    chk("R1 mid code", code, 2);
    chk("R1 mid ovf", ovf, 0);
    rst = 1'b0;
    for (int i = 0; i < 24; i++) begin
      cyc(1, 0);
      chk("R7 after reset", code, 2);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule